// File: doc/BRIEF.md
# Multi-Channel Soft-Start and Hiccup Sequencer

This block supervises four regulator channels: one switching channel and a parameterised number (three by default) of linear channels. While the bias-good input is high, each channel that is not held off runs its own soft-start. For a fixed number of clock cycles it drives a reference-clamp code that rises in proportion to elapsed time. It then holds the full-scale code. Channels started together reach full scale on the same cycle.

Each channel is protected on its own. The switching channel stops on any cycle in which its overcurrent input is high while it is ramping or running. A linear channel stops only when its undervoltage input stays high for a run of consecutive cycles. Undervoltage is not watched during roughly the first quarter of that channel's ramp. A stopped channel stays off for three soft-start periods, then ramps again. The other channels carry on undisturbed.

A per-channel hold-off input forces a channel off. Releasing it starts a fresh ramp for that channel alone. Dropping the bias-good input returns every channel to off and clears all counters.

Top module: `softstart_sequencer`

## Requirements
- R1: While rst_n is low, every chan_en bit is 0 and every ref_clamp field is 0. While por_ok stays low after reset, they remain 0.
- R2: A channel that is off, with por_ok high and its chan_off bit low, enters its ramp at the next clock edge. In the k-th ramp cycle (k = 0 … SS_CYCLES-1) its chan_en is 1 and its ref_clamp field (bits [i*CODE_W +: CODE_W] for channel i) equals floor((k+1)·(2^CODE_W−1)/SS_CYCLES).
- R3: A ramp lasts exactly SS_CYCLES cycles. After it, the field holds the full-scale code 2^CODE_W−1. Channels that start together show equal codes on every cycle.
- R4: A fault stops only the faulting channel. Its chan_en falls and its clamp goes to 0 one cycle after the fault is sampled. The other channels' outputs are unchanged.
- R5: After a fault stop, the channel stays off with clamp 0 for exactly WAIT_PERIODS·SS_CYCLES cycles (3·SS_CYCLES by default). It then begins a new ramp at code floor((2^CODE_W−1)/SS_CYCLES).
- R6: Channel 0 (switching) samples oc_trip on every cycle of its ramp and run, with no masking and no filtering. A single sampled high value stops it.
- R7: uv_low[j] stops channel j+1 only after it has been sampled high on GLITCH_CYCLES consecutive monitored cycles. Shorter pulses leave the channel running.
- R8: For a linear channel, undervoltage is ignored during ramp cycles 0 … SS_CYCLES/4−1. With uv_low held high from the start of a ramp, chan_en stays high for exactly SS_CYCLES/4 + GLITCH_CYCLES cycles.
- R9: While a chan_off bit is high, that channel is off with clamp 0, including during a hiccup wait. On release it ramps from the next edge without waiting out any pending hiccup.
- R10: A low por_ok forces all channels off, with clamps 0, at the next edge and discards pending hiccup waits. When por_ok rises again, all channels ramp together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| por_ok | input | 1 | Bias supply above its threshold |
| oc_trip | input | 1 | Overcurrent comparator of the switching channel (channel 0) |
| uv_low | input | NUM_LIN | Undervoltage comparators (feedback below 70% of reference); bit j belongs to channel j+1 |
| chan_off | input | NUM_LIN+1 | Per-channel hold-off; bit i for channel i |
| chan_en | output | NUM_LIN+1 | Per-channel enable |
| ref_clamp | output | (NUM_LIN+1)·CODE_W | Per-channel reference-clamp codes, channel i in bits [i·CODE_W +: CODE_W] |

## Verification
Every input is sampled at one clock edge, and the outputs come straight from state registers. Any stimulus is therefore visible on the enable and clamp outputs exactly one edge later.

- A ramp code for step k appears k+1 edges after a start.
- An overcurrent stop appears one edge after the trip.
- An undervoltage stop appears GLITCH_CYCLES edges after the input rises.
- A restart appears 3·SS_CYCLES samples after the stop.

The bench drives inputs and samples outputs on the falling edge. Wait and mask windows are checked by counting falling-edge samples until the enable changes, so a result that is one cycle early or late gives a different count.

// File: rtl/ssq_pkg.sv
package ssq_pkg;

  typedef enum logic [1:0] {
    CH_OFF  = 2'd0,
    CH_RAMP = 2'd1,
    CH_RUN  = 2'd2,
    CH_WAIT = 2'd3
  } ch_state_e;

  // clamp code for ramp step 'step' (0-based) of a ramp 'period' cycles long
  function automatic int unsigned ramp_code(input int unsigned step,
                                            input int unsigned period,
                                            input int unsigned full);
    return ((step + 1) * full) / period;
  endfunction

  // first ramp step on which undervoltage is watched
  function automatic int unsigned mask_point(input int unsigned period);
    return period / 4;
  endfunction

endpackage

// File: rtl/ssq_uv_filter.sv
module ssq_uv_filter #(
  parameter int unsigned GLITCH_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic watch,
  input  logic uv_in,
  output logic fault
);
  localparam int unsigned CW = $clog2(GLITCH_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(GLITCH_CYCLES - 1);

  logic [CW-1:0] run_q;
  logic          hit;

  assign hit   = watch & uv_in;
  assign fault = hit && (run_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= '0;
    else if (!hit) run_q <= '0;
    else if (!fault) run_q <= run_q + 1'b1;
  end
endmodule

// File: rtl/ssq_channel.sv
module ssq_channel #(
  parameter int unsigned SS_CYCLES    = 256,
  parameter int unsigned CODE_W       = 8,
  parameter int unsigned WAIT_PERIODS = 3,
  parameter int unsigned MASK_CYCLES  = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                por_ok,
  input  logic                hold_off,
  input  logic                fault,
  output ssq_pkg::ch_state_e  state,
  output logic                enable,
  output logic [CODE_W-1:0]   clamp,
  output logic                monitor_on
);
  import ssq_pkg::*;

  localparam int unsigned WAIT_CYCLES = WAIT_PERIODS * SS_CYCLES;
  localparam int unsigned CNT_W       = $clog2(WAIT_CYCLES + 1);
  localparam logic [CNT_W-1:0] RAMP_LAST = CNT_W'(SS_CYCLES - 1);
  localparam logic [CNT_W-1:0] WAIT_LAST = CNT_W'(WAIT_CYCLES - 1);
  localparam logic [CNT_W-1:0] MASK_AT   = CNT_W'(MASK_CYCLES);
  localparam int unsigned FULL = (1 << CODE_W) - 1;

  ch_state_e        state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             ramp_done, wait_done;

  assign ramp_done = (state_q == CH_RAMP) && (cnt_q == RAMP_LAST);
  assign wait_done = (state_q == CH_WAIT) && (cnt_q == WAIT_LAST);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    if (!por_ok || hold_off) begin
      state_d = CH_OFF;
      cnt_d   = '0;
    end else begin
      case (state_q)
        CH_OFF: begin
          state_d = CH_RAMP;
          cnt_d   = '0;
        end
        CH_RAMP: begin
          if (fault) begin
            state_d = CH_WAIT;
            cnt_d   = '0;
          end else if (ramp_done) begin
            state_d = CH_RUN;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        CH_RUN: begin
          if (fault) begin
            state_d = CH_WAIT;
            cnt_d   = '0;
          end
        end
        default: begin
          if (wait_done) begin
            state_d = CH_RAMP;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CH_OFF;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  always_comb begin
    case (state_q)
      CH_RAMP: clamp = CODE_W'(ramp_code(32'(cnt_q), SS_CYCLES, FULL));
      CH_RUN:  clamp = CODE_W'(FULL);
      default: clamp = '0;
    endcase
  end

  assign state      = state_q;
  assign enable     = (state_q == CH_RAMP) || (state_q == CH_RUN);
  assign monitor_on = (state_q == CH_RUN) || ((state_q == CH_RAMP) && (cnt_q >= MASK_AT));
endmodule

// File: rtl/softstart_sequencer.sv
module softstart_sequencer #(
  parameter int unsigned NUM_LIN       = 3,
  parameter int unsigned SS_CYCLES     = 256,
  parameter int unsigned CODE_W        = 8,
  parameter int unsigned GLITCH_CYCLES = 16,
  parameter int unsigned WAIT_PERIODS  = 3
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               por_ok,
  input  logic                               oc_trip,
  input  logic [NUM_LIN-1:0]                 uv_low,
  input  logic [NUM_LIN:0]                   chan_off,
  output logic [NUM_LIN:0]                   chan_en,
  output logic [(NUM_LIN+1)*CODE_W-1:0]      ref_clamp
);
  localparam int unsigned NCH         = NUM_LIN + 1;
  localparam int unsigned MASK_CYCLES = ssq_pkg::mask_point(SS_CYCLES);

  // named internal events, visible to the bound checker
  ssq_pkg::ch_state_e   ch_state [NCH];
  logic [2*NCH-1:0]     ch_state_flat;
  logic [NCH-1:0]       ch_fault;
  logic [NCH-1:0]       ch_watch;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    ssq_channel #(
      .SS_CYCLES   (SS_CYCLES),
      .CODE_W      (CODE_W),
      .WAIT_PERIODS(WAIT_PERIODS),
      .MASK_CYCLES (MASK_CYCLES)
    ) i_channel (
      .clk       (clk),
      .rst_n     (rst_n),
      .por_ok    (por_ok),
      .hold_off  (chan_off[i]),
      .fault     (ch_fault[i]),
      .state     (ch_state[i]),
      .enable    (chan_en[i]),
      .clamp     (ref_clamp[i*CODE_W +: CODE_W]),
      .monitor_on(ch_watch[i])
    );

    assign ch_state_flat[2*i +: 2] = ch_state[i];

    if (i == 0) begin : g_switch
      // overcurrent: every cycle, unmasked, unfiltered
      assign ch_fault[i] = oc_trip;
    end else begin : g_linear
      ssq_uv_filter #(
        .GLITCH_CYCLES(GLITCH_CYCLES)
      ) i_filter (
        .clk  (clk),
        .rst_n(rst_n),
        .watch(ch_watch[i]),
        .uv_in(uv_low[i-1]),
        .fault(ch_fault[i])
      );
    end
  end
endmodule

// File: rtl/ssq_checker.sv
module ssq_checker #(
  parameter int unsigned NCH           = 4,
  parameter int unsigned CODE_W        = 8,
  parameter int unsigned SS_CYCLES     = 256,
  parameter int unsigned GLITCH_CYCLES = 16,
  parameter int unsigned WAIT_PERIODS  = 3
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  por_ok,
  input logic [NCH-1:0]        chan_off,
  input logic [NCH-1:0]        chan_en,
  input logic [NCH*CODE_W-1:0] ref_clamp,
  input logic [2*NCH-1:0]      ch_state_flat,
  input logic [NCH-1:0]        ch_fault,
  input logic [NCH-1:0]        ch_watch
);
  localparam int unsigned WAIT_CYCLES    = WAIT_PERIODS * SS_CYCLES;
  localparam int unsigned FAULT_EARLIEST = SS_CYCLES / 4 + GLITCH_CYCLES - 1;

  // R10
  por_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !por_ok |=> (chan_en == '0 && ref_clamp == '0));

  for (genvar i = 0; i < NCH; i++) begin : g_chk
    int unsigned wait_len, ramp_age;
    logic [1:0] st;
    assign st = ch_state_flat[2*i +: 2];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        wait_len <= 0;
        ramp_age <= 0;
      end else begin
        wait_len <= (st == ssq_pkg::CH_WAIT) ? wait_len + 1 : 0;
        ramp_age <= (st == ssq_pkg::CH_RAMP) ? ramp_age + 1 : 0;
      end
    end

    // R9
    hold_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      chan_off[i] |=> !chan_en[i]);

    // R4
    fault_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (chan_en[i] && ch_fault[i] && por_ok && !chan_off[i]) |=> (st == ssq_pkg::CH_WAIT));

    // R5
    wait_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ssq_pkg::CH_RAMP && $past(ch_state_flat[2*i +: 2]) == ssq_pkg::CH_WAIT)
        |-> (wait_len == WAIT_CYCLES));

    // R3
    ramp_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ssq_pkg::CH_RUN && $past(ch_state_flat[2*i +: 2]) == ssq_pkg::CH_RAMP)
        |-> (ramp_age == SS_CYCLES));

    // R2
    ramp_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ssq_pkg::CH_RAMP && $past(ch_state_flat[2*i +: 2]) == ssq_pkg::CH_RAMP)
        |-> (ref_clamp[i*CODE_W +: CODE_W] >= $past(ref_clamp[i*CODE_W +: CODE_W])));

    if (i > 0) begin : g_lin
      // R8
      uv_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_fault[i] && st == ssq_pkg::CH_RAMP) |-> (ramp_age >= FAULT_EARLIEST));
      // R7
      uv_watch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ch_fault[i] |-> ch_watch[i]);
    end
  end
endmodule

bind softstart_sequencer ssq_checker #(
  .NCH          (NCH),
  .CODE_W       (CODE_W),
  .SS_CYCLES    (SS_CYCLES),
  .GLITCH_CYCLES(GLITCH_CYCLES),
  .WAIT_PERIODS (WAIT_PERIODS)
) i_ssq_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .por_ok       (por_ok),
  .chan_off     (chan_off),
  .chan_en      (chan_en),
  .ref_clamp    (ref_clamp),
  .ch_state_flat(ch_state_flat),
  .ch_fault     (ch_fault),
  .ch_watch     (ch_watch)
);

// File: tb/test_softstart_sequencer.sv
module test_softstart_sequencer;
  localparam int CLK_PERIOD = 10;
  localparam int SS    = 64;
  localparam int CW    = 8;
  localparam int GL    = 4;
  localparam int MASK  = SS / 4;
  localparam int FULL  = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst_n, por_ok, oc_trip;
  logic [2:0] uv_low;
  logic [3:0] chan_off;
  logic [3:0] chan_en;
  logic [4*CW-1:0] ref_clamp;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  softstart_sequencer #(
    .NUM_LIN(3), .SS_CYCLES(SS), .CODE_W(CW), .GLITCH_CYCLES(GL), .WAIT_PERIODS(3)
  ) i_softstart_sequencer (
    .clk(clk), .rst_n(rst_n), .por_ok(por_ok), .oc_trip(oc_trip),
    .uv_low(uv_low), .chan_off(chan_off), .chan_en(chan_en), .ref_clamp(ref_clamp)
  );

  function automatic int exp_code(input int k);
    return ((k + 1) * FULL) / SS;
  endfunction

  function automatic int got(input int ch);
    return int'(ref_clamp[ch*CW +: CW]);
  endfunction

  task automatic check_eq(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    int n;
    bit ok;
    void'($urandom(32'd20240611));
    rst_n = 0; por_ok = 0; oc_trip = 0; uv_low = '0; chan_off = '0;
    tick(3);
    check_eq("R1 reset enables", int'(chan_en), 0);
    check_eq("R1 reset clamps", int'(ref_clamp), 0);
    rst_n = 1;
    tick(6);
    check_eq("R1 por low enables", int'(chan_en), 0);
    check_eq("R1 por low clamps", int'(ref_clamp), 0);

    // R2 / R3: joint ramp
    por_ok = 1;
    for (int k = 0; k < SS; k++) begin
      tick(1);
      check_eq("R2 ramp enables", int'(chan_en), 15);
      for (int ch = 0; ch < 4; ch++) check_eq("R2 R3 ramp code", got(ch), exp_code(k));
    end
    tick(1);
    for (int ch = 0; ch < 4; ch++) check_eq("R3 full code", got(ch), FULL);

    // R4 / R6: overcurrent in run stops channel 0 only
    oc_trip = 1;
    tick(1);
    oc_trip = 0;
    check_eq("R6 oc stop", int'(chan_en[0]), 0);
    check_eq("R4 others on", int'(chan_en[3:1]), 7);
    for (int ch = 1; ch < 4; ch++) check_eq("R4 others code", got(ch), FULL);

    // R5: wait length
    n = 0; ok = 1;
    while (!chan_en[0] && n < 10000) begin
      if (got(0) != 0) ok = 0;
      n++;
      tick(1);
    end
    check_eq("R5 wait cycles", n, 3 * SS);
    check_eq("R5 clamp zero in wait", int'(ok), 1);
    check_eq("R5 restart code", got(0), exp_code(0));

    // R6: overcurrent during ramp is not masked
    tick(1);
    oc_trip = 1;
    tick(1);
    oc_trip = 0;
    check_eq("R6 oc in ramp", int'(chan_en[0]), 0);

    // R9: hold-off during wait, release restarts at once
    chan_off[0] = 1;
    tick(1);
    check_eq("R9 held off", int'(chan_en[0]), 0);
    chan_off[0] = 0;
    tick(1);
    check_eq("R9 restart from wait", got(0), exp_code(0));
    tick(SS);
    check_eq("R3 ch0 full again", got(0), FULL);

    // R7: random short undervoltage pulses are ignored
    for (int r = 0; r < 8; r++) begin
      int ch = 1 + int'($urandom % 3);
      int len = 1 + int'($urandom % (GL - 1));
      tick(int'($urandom % 5));
      uv_low[ch-1] = 1;
      tick(len);
      uv_low[ch-1] = 0;
      tick(2);
      check_eq("R7 glitch ignored", int'(chan_en), 15);
    end

    // R7: sustained undervoltage on channel 1
    uv_low[0] = 1;
    for (int j = 1; j <= GL; j++) begin
      tick(1);
      check_eq("R7 sustained uv", int'(chan_en[1]), (j < GL) ? 1 : 0);
    end
    uv_low[0] = 0;
    check_eq("R4 uv isolation", int'(chan_en[3:2]), 3);

    // R9 hold on channel 2, then R8 mask window
    chan_off[2] = 1;
    tick(1);
    check_eq("R9 hold clamp", got(2), 0);
    tick(5);
    check_eq("R9 hold stays", int'(chan_en[2]), 0);
    uv_low[1] = 1;
    chan_off[2] = 0;
    n = 0;
    tick(1);
    while (chan_en[2] && n < 10000) begin
      n++;
      tick(1);
    end
    uv_low[1] = 0;
    check_eq("R8 mask plus filter", n, MASK + GL);

    // R8: long pulse wholly inside the mask is ignored
    chan_off[2] = 1;
    tick(1);
    chan_off[2] = 0;
    uv_low[1] = 1;
    tick(MASK + 1);
    uv_low[1] = 0;
    tick(3);
    check_eq("R8 masked pulse", int'(chan_en[2]), 1);

    // R9: channel 3 hold and release
    chan_off[3] = 1;
    tick(20);
    check_eq("R9 ch3 held", int'(chan_en[3]), 0);
    check_eq("R9 ch3 clamp", got(3), 0);
    chan_off[3] = 0;
    tick(1);
    check_eq("R9 ch3 restart", got(3), exp_code(0));

    // all back in run (ch1 after its wait and ramp)
    tick(5 * SS);
    check_eq("R5 all recovered", int'(chan_en), 15);
    for (int ch = 0; ch < 4; ch++) check_eq("R5 R3 recovered code", got(ch), FULL);

    // R10: por drop discards a pending wait
    oc_trip = 1;
    tick(1);
    oc_trip = 0;
    tick(10);
    por_ok = 0;
    tick(1);
    check_eq("R10 por drop enables", int'(chan_en), 0);
    check_eq("R10 por drop clamps", int'(ref_clamp), 0);
    por_ok = 1;
    tick(1);
    check_eq("R10 joint restart", int'(chan_en), 15);
    for (int ch = 0; ch < 4; ch++) check_eq("R10 restart code", got(ch), exp_code(0));

    tick(5);
    finish_run();
  end
endmodule